// File: doc/BRIEF.md
# Serial SAR Converter Sample Reader

This block is an SPI master that takes one sample from a serial successive-approximation converter. The converter can have 1, 2, 4 or 8 inputs and a resolution of 10, 12 or 13 bits. Both are fixed by parameters at elaboration. The user raises `req_i` together with an input number and a differential flag.

For converters with more than one input, the block first shifts out a command byte that selects the input. It then clocks in the reply while chip select stays low. Single-input converters have no data-in line, so for them the block only receives. When the frame ends, the block cuts the result field out of the received bytes. It presents the field as an integer on `data_o`, zero-extended or sign-extended as the variant requires, and pulses `valid_o` for one cycle.

The serial clock comes from a half-period tick divider. The interface works in clock-idle-low mode: `mosi_o` changes only while `sclk_o` is low, and `miso_i` is sampled on each rising edge of `sclk_o`, most significant bit first.

Top module: `sar_adc_reader`

## Requirements
- R1: For 4- and 8-input variants the command byte has a 1 at bit 6, the single-ended flag (the inverse of `diff_i`) at bit 5, and the input number at bits 4 and up from bit 2. All other bits are 0, and the byte is sent MSB first.
- R2: For 2-input variants the command byte has a 1 at bit 4, the single-ended flag at bit 3 and the input number at bit 2. All other bits are 0.
- R3: Single-input variants send no command: `mosi_o` stays low for the whole read, and the frame holds only the receive bits.
- R4: Chip select stays low for one continuous frame. The frame has 8 command clocks (multi-input only) plus 8 clocks for each receive byte, and the receive byte count is the resolution divided by 8, rounded up.
- R5: `sclk_o` is low whenever chip select is high. `mosi_o` changes only while `sclk_o` is low. Received bits are taken at rising edges of `sclk_o`, MSB first.
- R6: For 10-bit multi-input variants, with b0 and b1 the two receive bytes in arrival order, the result is (b0<<2)|(b1>>6), kept to 10 bits.
- R7: For 12-bit multi-input variants the result is (b0<<4)|(b1>>4), kept to 12 bits.
- R8: For single-input variants the result is (b0<<5)|(b1>>3) kept to 10 bits, or (b0<<7)|(b1>>1) kept to 12 bits.
- R9: For the 13-bit variant the result is the low 5 bits of b0 followed by b1, sign-extended from bit 12 to the full `data_o` width.
- R10: Unsigned results are zero-extended to the `data_o` width.
- R11: In differential mode the input number is encoded unchanged (the first input of the pair 0/1, 1/0, 2/3, 3/2 and so on), and only the single-ended flag is cleared.
- R12: `busy_o` rises the cycle after a request is accepted and falls in the cycle `valid_o` is high. A request that arrives while busy is ignored.
- R13: After a frame, chip select stays high for at least one full `sclk_o` period before the next frame starts. `valid_o` is a one-cycle pulse, and `data_o` changes only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read (taken only when not busy) |
| chan_i | input | CH_W | Input number (first input of the pair when differential) |
| diff_i | input | 1 | 1 = differential, 0 = single-ended |
| busy_o | output | 1 | A read is in progress |
| valid_o | output | 1 | One-cycle strobe: `data_o` holds a new sample |
| data_o | output | DATA_W | Extracted sample, zero- or sign-extended |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Reply data from the converter |

## Verification
A wrong bit counter or wrong tick handling shows as an SCLK edge count other than 16 or 24 within one chip-select window. It appears at the first read after the fault. A wrong field position or a missing sign extension corrupts `data_o` at the very strobe that closes the frame. Reply words with junk in the unused top bits, together with 13-bit codes at the extremes, expose masking and extension errors straight away.

A stuck sequencer state shows as `busy_o` that never falls, or as a request that is not ignored while busy. The ignored request carries a different input number, so its effect would show up in the next captured command byte.

// File: rtl/sar_adc_rd_pkg.sv
package sar_adc_rd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} rd_state_e;

  function automatic int unsigned rx_bytes(int unsigned res);
    return (res + 7) / 8;
  endfunction

  // bit position of the result LSB inside the receive word
  function automatic int unsigned field_lsb(int unsigned nch, int unsigned res);
    if (nch > 1)    return 8 * rx_bytes(res) - res;
    else if (res == 10) return 3;
    else if (res == 12) return 1;
    else            return 0;
  endfunction

  function automatic logic [7:0] build_cmd(int unsigned nch, logic [2:0] ch, logic diff);
    logic [7:0] c;
    c = '0;
    if (nch > 2) begin
      c[6]   = 1'b1;
      c[5]   = ~diff;
      c[4:2] = ch;
    end else begin
      c[4] = 1'b1;
      c[3] = ~diff;
      c[2] = ch[0];
    end
    return c;
  endfunction

endpackage

// File: rtl/sar_adc_rd_div.sv
module sar_adc_rd_div #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_adc_rd_seq.sv
module sar_adc_rd_seq
  import sar_adc_rd_pkg::*;
#(
  parameter int unsigned TOTAL   = 24,
  parameter int unsigned RX_BITS = 16,
  parameter bit          HAS_CMD = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [7:0]         cmd_i,
  input  logic               tick_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  output logic [RX_BITS-1:0] rx_o
);
  localparam int unsigned CNT_W = $clog2(TOTAL);

  rd_state_e          state_q;
  logic [CNT_W-1:0]   bit_q;
  logic [7:0]         tx_q;
  logic [RX_BITS-1:0] rx_q;
  logic               sclk_q, cs_q, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      gap_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          cs_q    <= 1'b0;
          bit_q   <= '0;
          tx_q    <= cmd_i;
        end
        ST_SHIFT: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[RX_BITS-2:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == CNT_W'(TOTAL - 1)) begin
              state_q <= ST_GAP;
              cs_q    <= 1'b1;
              gap_q   <= 1'b0;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) state_q <= ST_IDLE;
          else       gap_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_GAP) && tick_i && gap_q;
  assign sclk_o = sclk_q;
  assign cs_n_o = cs_q;
  assign rx_o   = rx_q;

  generate
    if (HAS_CMD) begin : g_cmd
      assign mosi_o = (state_q == ST_SHIFT) && tx_q[7];
    end else begin : g_rx_only
      assign mosi_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sar_adc_rd_unpack.sv
module sar_adc_rd_unpack
  import sar_adc_rd_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_BITS = 12,
  parameter int unsigned RX_BITS  = 16,
  parameter int unsigned DATA_W   = 16
) (
  input  logic [RX_BITS-1:0] rx_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam int unsigned LSB = field_lsb(NUM_CH, RES_BITS);
  localparam logic [RX_BITS-1:0] FMASK = RX_BITS'((64'd1 << RES_BITS) - 1);
  localparam logic [DATA_W-1:0]  EXT   = ~DATA_W'((64'd1 << RES_BITS) - 1);

  logic [RX_BITS-1:0] fld;
  assign fld = (rx_i >> LSB) & FMASK;

  generate
    if (RES_BITS == 13) begin : g_signed
      assign data_o = DATA_W'(fld) | (fld[RES_BITS-1] ? EXT : '0);
    end else begin : g_unsigned
      assign data_o = DATA_W'(fld);
    end
  endgenerate
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_adc_rd_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_BITS = 12,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              diff_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam bit          HAS_CMD  = (NUM_CH > 1);
  localparam int unsigned RX_BITS  = 8 * rx_bytes(RES_BITS);
  localparam int unsigned TOTAL    = (HAS_CMD ? 8 : 0) + RX_BITS;

  logic               busy, done, tick, start;
  logic [7:0]         cmd;
  logic [RX_BITS-1:0] rx;
  logic [DATA_W-1:0]  sample;
  logic               valid_q;
  logic [DATA_W-1:0]  data_q;

  assign start = req_i && !busy;
  assign cmd   = build_cmd(NUM_CH, 3'(chan_i), diff_i);

  sar_adc_rd_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk_i, .rst_ni, .en_i(busy), .tick_o(tick)
  );

  sar_adc_rd_seq #(.TOTAL(TOTAL), .RX_BITS(RX_BITS), .HAS_CMD(HAS_CMD)) seq_i (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .tick_i(tick), .miso_i,
    .busy_o(busy), .done_o(done), .sclk_o, .cs_n_o, .mosi_o, .rx_o(rx)
  );

  sar_adc_rd_unpack #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .RX_BITS(RX_BITS), .DATA_W(DATA_W)
  ) unpack_i (.rx_i(rx), .data_o(sample));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= done;
      if (done) data_q <= sample;
    end
  end

  assign busy_o  = busy;
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sar_adc_reader_chk.sv
module sar_adc_reader_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              sclk_o,
  input logic              cs_n_o,
  input logic              mosi_o
);
  // R5
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);
  // R5
  mosi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sclk_o);
  // R12
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (busy_o && !cs_n_o));
  // R12
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);
  // R12
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  // R13
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R13
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);
  // R4
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> busy_o);
endmodule

bind sar_adc_reader sar_adc_reader_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .valid_o(valid_o), .data_o(data_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
  .mosi_o(mosi_o)
);

// File: tb/sar_adc_reader_tb_top.sv
module adc_model #(
  parameter bit HAS_CMD = 1'b1
) (
  input  logic        clk,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic [15:0] reply,
  output logic        miso,
  output logic [7:0]  cmd,
  output int          rises,
  output logic        mosi_seen,
  output int          gap
);
  logic [23:0] frame;
  int idx = 0;
  bit active = 0;
  int hi = 0;

  initial begin
    miso = 0; cmd = 0; rises = 0; mosi_seen = 0; gap = 0;
  end

  always @(negedge cs_n or posedge cs_n or posedge sclk or negedge sclk) begin
    if (cs_n) active = 0;
    else if (!active) begin
      active = 1;
      frame = HAS_CMD ? {8'hC3, reply} : {reply, 8'h00};
      idx = 0;
      miso = frame[23];
      rises = 0; cmd = 0; mosi_seen = 0;
    end else if (sclk) begin
      if (rises < 8) cmd = {cmd[6:0], mosi};
      if (mosi) mosi_seen = 1;
      rises++;
    end else begin
      idx++;
      if (idx < 24) miso = frame[23-idx];
    end
  end

  always @(posedge clk) begin
    if (cs_n) hi <= hi + 1;
    else begin
      if (hi != 0) gap <= hi;
      hi <= 0;
    end
  end
endmodule

module sar_adc_reader_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        req   [4];
  logic [2:0]  chan  [4];
  logic        diff  [4];
  logic        busy  [4];
  logic        valid [4];
  logic [15:0] data  [4];
  logic        sclk  [4];
  logic        cs_n  [4];
  logic        mosi  [4];
  logic        miso  [4];
  logic [15:0] reply [4];
  logic [7:0]  cmd   [4];
  int          rises [4];
  logic        mseen [4];
  int          gap   [4];
  int          vcnt  [4];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  for (genvar g = 0; g < 4; g++) begin : g_inst
    localparam int NCH = (g == 0) ? 8 : (g == 2) ? 2 : 1;
    localparam int RES = (g == 0) ? 12 : (g == 1) ? 13 : (g == 2) ? 10 : 12;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    sar_adc_reader #(.NUM_CH(NCH), .RES_BITS(RES), .HALF_DIV(2), .DATA_W(16)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req[g]), .chan_i(chan[g][CHW-1:0]),
      .diff_i(diff[g]), .busy_o(busy[g]), .valid_o(valid[g]), .data_o(data[g]),
      .sclk_o(sclk[g]), .cs_n_o(cs_n[g]), .mosi_o(mosi[g]), .miso_i(miso[g])
    );
    adc_model #(.HAS_CMD(NCH > 1)) mdl_i (
      .clk(clk), .sclk(sclk[g]), .cs_n(cs_n[g]), .mosi(mosi[g]), .reply(reply[g]),
      .miso(miso[g]), .cmd(cmd[g]), .rises(rises[g]), .mosi_seen(mseen[g]), .gap(gap[g])
    );
  end

  initial for (int i = 0; i < 4; i++) vcnt[i] = 0;
  always @(posedge clk) for (int i = 0; i < 4; i++) if (valid[i]) vcnt[i] <= vcnt[i] + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_data(input int g, input logic [15:0] w);
    int b0, b1, v;
    b0 = int'(w[15:8]); b1 = int'(w[7:0]);
    case (g)
      0: v = ((b0 << 4) | (b1 >> 4)) & 'hFFF;
      1: begin
        v = ((b0 & 'h1F) << 8) | b1;
        if (v & 'h1000) v = v | 'hE000;
      end
      2: v = ((b0 << 2) | (b1 >> 6)) & 'h3FF;
      default: v = ((b0 << 7) | (b1 >> 1)) & 'hFFF;
    endcase
    return v & 'hFFFF;
  endfunction

  function automatic logic [15:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:8];
  endfunction

  task automatic run_txn(input int g, input int ch, input bit df, input logic [15:0] w);
    int n, v0, exp_cmd, exp_rises;
    string dtag;
    reply[g] = w;
    @(negedge clk);
    while (busy[g]) @(negedge clk);
    v0 = vcnt[g];
    req[g] = 1; chan[g] = 3'(ch); diff[g] = df;
    @(negedge clk);
    req[g] = 0;
    repeat (3) @(negedge clk);
    // R12: request while busy, different input and mode, must be ignored
    req[g] = 1; chan[g] = 3'(ch ^ 1); diff[g] = !df;
    @(negedge clk);
    req[g] = 0;
    n = 0;
    while (!valid[g] && n < 2000) begin @(negedge clk); n++; end
    dtag = (g == 0) ? "R7" : (g == 1) ? "R9" : (g == 2) ? "R6 R10" : "R8 R10";
    chk(valid[g] === 1'b1, "R12 valid seen", int'(valid[g]), 1);
    chk(data[g] === 16'(exp_data(g, w)), dtag, int'(data[g]), exp_data(g, w));
    chk(busy[g] === 1'b0, "R12 busy low at valid", int'(busy[g]), 0);
    exp_rises = (g == 0 || g == 2) ? 24 : 16;
    chk(rises[g] == exp_rises, "R4 clock count", rises[g], exp_rises);
    if (g == 0) begin
      exp_cmd = 64 | ((df ? 0 : 1) << 5) | (ch << 2);
      chk(cmd[g] === 8'(exp_cmd), df ? "R1 R11 cmd" : "R1 cmd", int'(cmd[g]), exp_cmd);
    end else if (g == 2) begin
      exp_cmd = 16 | ((df ? 0 : 1) << 3) | (ch << 2);
      chk(cmd[g] === 8'(exp_cmd), df ? "R2 R11 cmd" : "R2 cmd", int'(cmd[g]), exp_cmd);
    end else begin
      chk(mseen[g] === 1'b0, "R3 mosi idle", int'(mseen[g]), 0);
    end
    chk(gap[g] >= 4, "R13 cs high gap", gap[g], 4);
    repeat (2) @(negedge clk);
    chk(vcnt[g] == v0 + 1, "R13 single strobe", vcnt[g] - v0, 1);
  endtask

  localparam logic [15:0] EDGE13 [6] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'hE0FF, 16'hF123};

  initial begin
    for (int i = 0; i < 4; i++) begin
      req[i] = 0; chan[i] = 0; diff[i] = 0; reply[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(cs_n[i] === 1'b1 && sclk[i] === 1'b0, "R5 reset idle bus", int'({cs_n[i], sclk[i]}), 2);
      chk(busy[i] === 1'b0 && valid[i] === 1'b0 && data[i] === 16'h0,
          "R12 reset state", int'({busy[i], valid[i]}), 0);
    end
    for (int ch = 0; ch < 8; ch++)
      for (int df = 0; df < 2; df++)
        for (int k = 0; k < 3; k++) run_txn(0, ch, df[0], next_word());
    for (int ch = 0; ch < 2; ch++)
      for (int df = 0; df < 2; df++)
        for (int k = 0; k < 4; k++) run_txn(2, ch, df[0], next_word());
    for (int k = 0; k < 6; k++) run_txn(1, 0, 1'b1, EDGE13[k]);
    for (int k = 0; k < 10; k++) run_txn(1, 0, 1'b1, next_word());
    for (int k = 0; k < 8; k++) run_txn(3, 0, 1'b1, next_word());
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 busy never released actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule